// File: doc/BRIEF.md
# Low-Power Reverse Response Generator

This block lives on the peripheral end of a serial display link and produces the traffic that flows back to the host while the link runs in low-power reverse direction. Three kinds of request feed it: a tearing-effect notice, an acknowledge, and a short read response. Tearing-effect notices and clean acknowledges leave as single fixed trigger bytes. When the receive path has flagged any error since the last report, an acknowledge is replaced by a four-byte short packet that carries the accumulated error bits.

Error flags from the receive path are OR-ed into a 16-bit sticky register on every cycle. Sending a report empties that register. A flag that arrives in the very cycle the register is captured for a report is kept and goes out in the next report. Requests are held as pending flags. When the serializer is free, the highest-priority pending request is framed and shifted out one bit per cycle. The frame is marked by a valid strobe, a first-bit pulse and a last-bit pulse.

Top module: `lp_reverse_responder`

## Requirements
- R1: After reset, ser_valid, tx_start, tx_done and busy are all low.
- R2: A tearing-effect request produces an 8-bit frame whose bits, in order of transmission, are 0,1,0,1,1,1,0,1.
- R3: An acknowledge request with an empty error register produces an 8-bit frame whose bits, in order of transmission, are 0,0,1,0,0,0,0,1.
- R4: An acknowledge request with a non-zero error register produces a 32-bit frame of four bytes, sent in this order: identifier {vc_id[1:0], 6'h02}, error bits 7:0, error bits 15:8, ECC. Every byte is sent least-significant bit first.
- R5: The ECC byte of every 32-bit frame has bits 7:6 at zero. Bits 5:0 are the XOR of one code per set header bit, where the header bits are numbered 0..23 starting at the identifier LSB. Header bits 0..19 take the six-bit values with exactly three ones, in ascending order. Header bits 20..23 take 0x1F, 0x2F, 0x37 and 0x3B.
- R6: Sending an error report clears the error register, so a following acknowledge with no new errors is a plain trigger.
- R7: An error flag sampled in the same cycle the register is captured for a report is absent from that report and appears in the next one.
- R8: Error flags raised in different cycles accumulate by OR into one report.
- R9: When tearing-effect and acknowledge requests are pending together, the tearing-effect frame is sent first and the acknowledge follows.
- R10: A read request produces a 32-bit frame sent in this order: identifier {vc_id, rd_type}, rd_data[7:0], rd_data[15:8], ECC, with the same bit order and ECC as R4 and R5.
- R11: busy is high from the cycle after a request is sampled until the last bit has left. tx_start is high on exactly the first bit of a frame, and tx_done on exactly the last bit. ser_valid falls right after tx_done.
- R12: A request that arrives while a frame is being shifted is held and sent after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_id | input | 2 | Virtual channel placed in packet identifiers |
| err_flags | input | 16 | Per-cycle error flags from the receive path |
| te_req | input | 1 | One-cycle request for a tearing-effect trigger |
| ack_req | input | 1 | One-cycle request for an acknowledge |
| rd_req | input | 1 | One-cycle request for a short read response |
| rd_type | input | 6 | Data type of the read response |
| rd_data | input | 16 | Two payload bytes of the read response |
| ser_bit | output | 1 | Serial data, one bit per cycle |
| ser_valid | output | 1 | ser_bit carries a frame bit |
| tx_start | output | 1 | First bit of a frame |
| tx_done | output | 1 | Last bit of a frame |
| busy | output | 1 | A request is pending or a frame is in flight |

## Verification
The assertions assume that the request lines are one-cycle pulses, and that vc_id, rd_type and rd_data do not change while a request is pending, because these fields are sampled only when the frame is loaded. err_flags may take any value in any cycle. The stimulus drives every input on the falling edge and changes vc_id and the read fields only while the block is idle. It places error pulses deliberately on the load edge, and it raises requests in the middle of a frame. These cases exercise the capture window and the pending-request path.

// File: rtl/rrg_pkg.sv
package rrg_pkg;
    localparam int VC_W    = 2;
    localparam int DT_W    = 6;
    localparam int ERR_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int HDR_W   = 3 * BYTE_W;
    localparam int FRAME_W = 4 * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    // Trigger bytes stored so that LSB-first shifting yields the wire order.
    localparam logic [BYTE_W-1:0] TRIG_TEAR = 8'hBA;
    localparam logic [BYTE_W-1:0] TRIG_ACK  = 8'h84;
    localparam logic [DT_W-1:0]   DT_ERRRPT = 6'h02;

    localparam logic [CNT_W-1:0] LEN_BYTE  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LEN_FRAME = CNT_W'(FRAME_W - 1);

    typedef enum logic [1:0] {SRC_NONE, SRC_TEAR, SRC_ACK, SRC_READ} src_e;

    // Header check byte: every header bit owns a six-bit code; weight-3 codes
    // first in ascending order, then weight-5 codes.
    function automatic logic [BYTE_W-1:0] hdr_ecc(input logic [HDR_W-1:0] hdr);
        logic [5:0] par;
        int idx;
        par = '0;
        idx = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < 64; v++) begin
                if ($countones(v[5:0]) == w && idx < HDR_W) begin
                    if (hdr[idx]) par ^= v[5:0];
                    idx++;
                end
            end
        end
        return {2'b00, par};
    endfunction
endpackage

// File: rtl/rrg_err_accum.sv
module rrg_err_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] err_in,
    input  logic         clr,
    output logic [W-1:0] acc
);
    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.acc = (clr ? '0 : st_q.acc) | err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;

    // Sticky bits never drop without a clear.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((acc & $past(acc)) == $past(acc)));

    // A flag seen in the capture cycle survives the clear.
    p_keep_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((acc & $past(err_in)) == $past(err_in)));
endmodule

// File: rtl/rrg_pick.sv
module rrg_pick
    import rrg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic te_req,
    input  logic ack_req,
    input  logic rd_req,
    input  logic take,
    output src_e sel,
    output logic any_pend
);
    typedef struct packed {
        logic tear;
        logic ack;
        logic rd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        if (st_q.tear)     sel = SRC_TEAR;
        else if (st_q.ack) sel = SRC_ACK;
        else if (st_q.rd)  sel = SRC_READ;
        else               sel = SRC_NONE;

        st_d.tear = (st_q.tear & ~(take && sel == SRC_TEAR)) | te_req;
        st_d.ack  = (st_q.ack  & ~(take && sel == SRC_ACK))  | ack_req;
        st_d.rd   = (st_q.rd   & ~(take && sel == SRC_READ)) | rd_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_pend = st_q.tear | st_q.ack | st_q.rd;

    // Serving a tearing notice leaves a pending acknowledge untouched.
    p_tear_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.tear && st_q.ack) |=> st_q.ack);

    // A pending request stays until it is served.
    p_hold_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd && !(take && sel == SRC_READ)) |=> st_q.rd);
endmodule

// File: rtl/rrg_shifter.sv
module rrg_shifter #(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] len_m1,
    output logic          bit_o,
    output logic          active_o,
    output logic          first_o,
    output logic          last_o
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          act;
        logic          first;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh    = din;
            st_d.cnt   = len_m1;
            st_d.act   = 1'b1;
            st_d.first = 1'b1;
        end else if (st_q.act) begin
            st_d.sh    = st_q.sh >> 1;
            st_d.first = 1'b0;
            if (st_q.cnt == '0) st_d.act = 1'b0;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o    = st_q.sh[0];
    assign active_o = st_q.act;
    assign first_o  = st_q.act & st_q.first;
    assign last_o   = st_q.act & (st_q.cnt == '0);

    // A frame is never cut short.
    p_full_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && st_q.cnt != '0) |=> st_q.act);

    // No new frame is loaded over one in flight.
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> !load);
endmodule

// File: rtl/lp_reverse_responder.sv
module lp_reverse_responder
    import rrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VC_W-1:0]   vc_id,
    input  logic [ERR_W-1:0]  err_flags,
    input  logic              te_req,
    input  logic              ack_req,
    input  logic              rd_req,
    input  logic [DT_W-1:0]   rd_type,
    input  logic [ERR_W-1:0]  rd_data,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              tx_start,
    output logic              tx_done,
    output logic              busy
);
    logic [ERR_W-1:0]   acc;
    logic               any_pend;
    src_e               sel;
    logic               active;
    logic               load;
    logic               err_hit;
    logic               clr;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len_m1;
    logic [HDR_W-1:0]   hdr;

    assign load    = !active && any_pend;
    assign err_hit = |acc;
    assign clr     = load && sel == SRC_ACK && err_hit;

    always_comb begin
        hdr    = '0;
        frame  = '0;
        len_m1 = LEN_BYTE;
        unique case (sel)
            SRC_TEAR: frame = FRAME_W'(TRIG_TEAR);
            SRC_ACK: begin
                if (err_hit) begin
                    hdr    = {acc, vc_id, DT_ERRRPT};
                    frame  = {hdr_ecc(hdr), hdr};
                    len_m1 = LEN_FRAME;
                end else begin
                    frame = FRAME_W'(TRIG_ACK);
                end
            end
            SRC_READ: begin
                hdr    = {rd_data, vc_id, rd_type};
                frame  = {hdr_ecc(hdr), hdr};
                len_m1 = LEN_FRAME;
            end
            default: frame = '0;
        endcase
    end

    rrg_err_accum #(.W(ERR_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_in (err_flags),
        .clr    (clr),
        .acc    (acc)
    );

    rrg_pick u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .te_req   (te_req),
        .ack_req  (ack_req),
        .rd_req   (rd_req),
        .take     (load),
        .sel      (sel),
        .any_pend (any_pend)
    );

    rrg_shifter #(.W(FRAME_W), .CW(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .din      (frame),
        .len_m1   (len_m1),
        .bit_o    (ser_bit),
        .active_o (active),
        .first_o  (tx_start),
        .last_o   (tx_done)
    );

    assign ser_valid = active;
    assign busy      = active | any_pend;

    p_start_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> ser_valid);

    p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !ser_valid);

    p_valid_means_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> busy);

    p_report_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == $past(err_flags)));
endmodule

// File: tb/lp_reverse_responder_bench.sv
module lp_reverse_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  vc_id = '0;
    logic [15:0] err_flags = '0;
    logic        te_req = 1'b0, ack_req = 1'b0, rd_req = 1'b0;
    logic [5:0]  rd_type = '0;
    logic [15:0] rd_data = '0;
    logic        ser_bit, ser_valid, tx_start, tx_done, busy;

    int total = 0;
    int fails = 0;

    localparam logic [5:0] CODES [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};

    always #10 clk = ~clk;

    lp_reverse_responder u_lp_reverse_responder (
        .clk(clk), .rst_n(rst_n), .vc_id(vc_id), .err_flags(err_flags),
        .te_req(te_req), .ack_req(ack_req), .rd_req(rd_req),
        .rd_type(rd_type), .rd_data(rd_data), .ser_bit(ser_bit),
        .ser_valid(ser_valid), .tx_start(tx_start), .tx_done(tx_done),
        .busy(busy));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wire_order8(input logic [7:0] seq);
        logic [31:0] r = '0;
        for (int i = 0; i < 8; i++) r[i] = seq[7-i];
        return r;
    endfunction

    function automatic logic [31:0] exp_short(input logic [1:0] vc, input logic [5:0] dt,
                                              input logic [15:0] pl);
        logic [23:0] h;
        logic [5:0]  e;
        h = {pl, vc, dt};
        e = '0;
        for (int i = 0; i < 24; i++) if (h[i]) e ^= CODES[i];
        return {2'b00, e, h};
    endfunction

    task automatic req(input logic t, input logic a, input logic r);
        @(negedge clk);
        te_req = t; ack_req = a; rd_req = r;
        @(negedge clk);
        te_req = 1'b0; ack_req = 1'b0; rd_req = 1'b0;
        chk("R11 busy after accept", {31'b0, busy}, 32'd1);
    endtask

    task automatic get_frame(input string tag, input logic [31:0] exp, input int exp_n);
        logic [31:0] bits = '0;
        int n = 0, waitc = 0, starts = 0, donepos = -1, startpos = -1;
        while (!ser_valid && waitc < 100) begin @(negedge clk); waitc++; end
        if (!ser_valid) begin
            chk({tag, " frame missing"}, 32'd0, 32'd1);
            return;
        end
        while (ser_valid && n < 40) begin
            if (n < 32) bits[n] = ser_bit;
            if (tx_start) begin starts++; startpos = n; end
            if (tx_done) donepos = n;
            if (!busy) chk("R11 busy low in frame", 32'd0, 32'd1);
            n++;
            @(negedge clk);
        end
        chk({tag, " bits"}, bits, exp);
        chk({tag, " length"}, n, exp_n);
        chk("R11 start on first bit", {starts[15:0], startpos[15:0]}, {16'd1, 16'd0});
        chk("R11 done on last bit", donepos, n - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] te_exp, ack_exp;
        te_exp  = wire_order8(8'b01011101);
        ack_exp = wire_order8(8'b00100001);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs in reset", {28'b0, ser_valid, tx_start, tx_done, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {28'b0, ser_valid, tx_start, tx_done, busy}, 32'd0);

        // R2 tearing trigger
        req(1, 0, 0);
        get_frame("R2 tear trigger", te_exp, 8);
        // R3 clean acknowledge
        req(0, 1, 0);
        get_frame("R3 plain ack", ack_exp, 8);

        // R4 R5 R6 sweep of single error bits over all channels
        for (int vc = 0; vc < 4; vc++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                vc_id = vc[1:0];
                err_flags = 16'(1 << b);
                @(negedge clk);
                err_flags = '0;
                req(0, 1, 0);
                get_frame("R4 R5 error report", exp_short(vc[1:0], 6'h02, 16'(1 << b)), 32);
                req(0, 1, 0);
                get_frame("R6 ack after report", ack_exp, 8);
            end
        end

        // R8 accumulation over separate cycles
        vc_id = 2'd1;
        @(negedge clk); err_flags = 16'h0001;
        @(negedge clk); err_flags = 16'h0000;
        @(negedge clk); err_flags = 16'h8000;
        @(negedge clk); err_flags = 16'h0100;
        @(negedge clk); err_flags = 16'h0000;
        req(0, 1, 0);
        get_frame("R8 accumulated report", exp_short(2'd1, 6'h02, 16'h8101), 32);

        // R7 flag on the capture edge goes to the next report
        @(negedge clk); err_flags = 16'h0002;
        @(negedge clk); err_flags = 16'h0000;
        ack_req = 1'b1;
        @(negedge clk); ack_req = 1'b0; err_flags = 16'h0040;
        @(negedge clk); err_flags = 16'h0000;
        get_frame("R7 capture-cycle report", exp_short(2'd1, 6'h02, 16'h0002), 32);
        req(0, 1, 0);
        get_frame("R7 deferred flag report", exp_short(2'd1, 6'h02, 16'h0040), 32);

        // R9 simultaneous requests
        req(1, 1, 0);
        get_frame("R9 tear first", te_exp, 8);
        get_frame("R9 ack second", ack_exp, 8);

        // R12 request during a frame
        req(1, 0, 0);
        fork
            begin
                repeat (4) @(negedge clk);
                ack_req = 1'b1;
                @(negedge clk);
                ack_req = 1'b0;
            end
            get_frame("R12 frame in flight", te_exp, 8);
        join
        get_frame("R12 held ack", ack_exp, 8);

        // R10 read responses over types, data and channels
        for (int t = 0; t < 64; t += 9) begin
            @(negedge clk);
            vc_id   = t[1:0];
            rd_type = t[5:0];
            rd_data = 16'(16'hA55A ^ (t * 16'h0137));
            req(0, 0, 1);
            get_frame("R10 read response",
                      exp_short(t[1:0], t[5:0], 16'(16'hA55A ^ (t * 16'h0137))), 32);
        end

        @(negedge clk);
        chk("R1 idle at end", {28'b0, ser_valid, tx_start, tx_done, busy}, 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule